// File: doc/BRIEF.md
# Masked condition field writer

This block produces the next value of one 4-bit condition field from a source operand, a 4-bit select mask, a 4-bit polarity pattern (called mode) and a merge flag. The source is either an integer operand or another 4-bit condition field. An integer source can be applied in two ways: its least significant bit is tested against every mode bit, or its four low bits are each tested against the matching mode bit. A field source is masked, optionally merged with the old destination value, and then flipped bit by bit by the mode pattern. Bits never move between positions.

The merge flag picks between a plain overwrite, where every bit outside the mask becomes zero and the old field is not needed, and a read-modify-write, where bits outside the mask keep the old destination value. An optional per-element predicate either zeroes the whole field (when zeroing is enabled) or drops the write. The result leaves through a register stage as a field value with a write enable. Storage of the condition fields is outside the block: the caller supplies the old destination value and applies the write.

Top module: `mcw_field_writer`

## Requirements
- R1: When `src_is_zero` is 1 the integer source is taken as all zeros, whatever `src_int` holds.
- R2: With `variant` = 2'b00 (broadcast) and predicate true, result bit k is `mask[k] & (mode[k] == a[0])`, where a is the integer source after R1, before the merge of R4 is applied.
- R3: With `variant` = 2'b01 (per-bit) and predicate true, result bit k is `mask[k] & (mode[k] == a[k])` for k = 0..3 counted from the integer LSB; integer bits 4 and up have no effect.
- R4: For both integer variants, when `merge` = 0 every bit whose mask bit is 0 is written as 0; when `merge` = 1 every such bit is written with the matching bit of `old_field`.
- R5: With `variant` = 2'b10 (field copy) and predicate true, the result is `((mask & src_field) | (merge ? old_field & ~mask : 0)) ^ mode`.
- R6: With a zero integer source, broadcast variant and `merge` = 1, mode 4'b0000 sets every masked bit to 1 and mode 4'b1111 clears every masked bit, leaving the others unchanged.
- R7: When `pred_bit` = 0 and `zero_en` = 1 on a legal variant, the write is made and all four bits are 0, whatever the source.
- R8: When `pred_bit` = 0 and `zero_en` = 0, `wr_en` stays 0 and no write is made.
- R9: `variant` = 2'b11 is reserved: it never raises `wr_en`.
- R10: A request sampled at a rising clock edge shows on `wr_en`/`field_out` right after that edge; with no request `wr_en` is 0 after the next edge, and reset forces `wr_en` and `field_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| variant | input | 2 | 00 broadcast integer, 01 per-bit integer, 10 field copy, 11 reserved |
| src_int | input | XLEN | Integer source operand |
| src_is_zero | input | 1 | Source register index is zero: use the value zero |
| src_field | input | 4 | Source condition field (field copy variant) |
| old_field | input | 4 | Current value of the destination field |
| mask | input | 4 | Bit select mask |
| mode | input | 4 | Polarity pattern |
| merge | input | 1 | 1 keeps unmasked destination bits, 0 clears them |
| pred_bit | input | 1 | Predicate bit of this element |
| zero_en | input | 1 | Zeroing on a false predicate |
| wr_en | output | 1 | Destination field write enable |
| field_out | output | 4 | New destination field value |

## Verification
A fault in the per-bit match logic or in the merge term shows on `field_out` one clock after the request, as a wrong bit in a position picked by the mask, so sweeping every mask and mode value against every source nibble exposes it within a single request. A wrong predicate or variant decode shows in the same cycle as a `wr_en` that rises when it should stay low, or stays low when a zeroing write is due. Because the register stage only loads on a write, a dropped or spurious enable is visible at once and does not hide behind a held value.

// File: rtl/mcw_pkg.sv
package mcw_pkg;

   localparam int unsigned FIELD_W = 4;

   typedef enum logic [1:0] {
      MCW_BCAST  = 2'b00,
      MCW_PERBIT = 2'b01,
      MCW_FCOPY  = 2'b10,
      MCW_RSVD   = 2'b11
   } mcw_variant_e;

   typedef struct packed {
      logic               we;
      logic [FIELD_W-1:0] val;
   } mcw_wr_t;

endpackage

// File: rtl/mcw_int_match.sv
module mcw_int_match
   import mcw_pkg::*;
#(
   parameter int unsigned XLEN = 64
) (
   input  logic [XLEN-1:0]    src_int,
   input  logic               src_is_zero,
   input  logic               bcast,
   input  logic [FIELD_W-1:0] mask,
   input  logic [FIELD_W-1:0] mode,
   output logic [FIELD_W-1:0] hit
);

   generate
      if (XLEN < FIELD_W) begin : g_bad_xlen
         $error("mcw_int_match: XLEN must be at least FIELD_W");
      end
   endgenerate

   logic [FIELD_W-1:0] low_bits;
   assign low_bits = src_is_zero ? '0 : src_int[FIELD_W-1:0];

   generate
      if (XLEN > FIELD_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^src_int[XLEN-1:FIELD_W];
      end
   endgenerate

   for (genvar k = 0; k < FIELD_W; k++) begin : g_bit
      logic probe;
      assign probe  = bcast ? low_bits[0] : low_bits[k];
      assign hit[k] = mask[k] & ~(mode[k] ^ probe);
   end

endmodule

// File: rtl/mcw_combine.sv
module mcw_combine
   import mcw_pkg::*;
(
   input  mcw_variant_e       variant,
   input  logic [FIELD_W-1:0] hit,
   input  logic [FIELD_W-1:0] src_field,
   input  logic [FIELD_W-1:0] old_field,
   input  logic [FIELD_W-1:0] mask,
   input  logic [FIELD_W-1:0] mode,
   input  logic               merge,
   output logic [FIELD_W-1:0] val,
   output logic               legal
);

   logic [FIELD_W-1:0] keep;

   always_comb begin
      keep = merge ? (old_field & ~mask) : '0;
      unique case (variant)
         MCW_BCAST, MCW_PERBIT: begin
            val   = hit | keep;
            legal = 1'b1;
         end
         MCW_FCOPY: begin
            val   = ((mask & src_field) | keep) ^ mode;
            legal = 1'b1;
         end
         default: begin
            val   = '0;
            legal = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/mcw_pred_gate.sv
module mcw_pred_gate
   import mcw_pkg::*;
#(
   parameter bit PRED_EN = 1'b1
) (
   input  logic               legal,
   input  logic [FIELD_W-1:0] val,
   input  logic               pred_bit,
   input  logic               zero_en,
   output mcw_wr_t            wr
);

   generate
      if (PRED_EN) begin : g_pred
         always_comb begin
            if (pred_bit) begin
               wr.we  = legal;
               wr.val = val;
            end else if (zero_en) begin
               wr.we  = legal;
               wr.val = '0;
            end else begin
               wr.we  = 1'b0;
               wr.val = '0;
            end
         end
      end else begin : g_nopred
         logic unused_pred;
         assign unused_pred = pred_bit ^ zero_en;
         assign wr.we  = legal;
         assign wr.val = val;
      end
   endgenerate

endmodule

// File: rtl/mcw_field_writer.sv
module mcw_field_writer
   import mcw_pkg::*;
#(
   parameter int unsigned XLEN    = 64,
   parameter bit          PRED_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         variant,
   input  logic [XLEN-1:0]    src_int,
   input  logic               src_is_zero,
   input  logic [3:0]         src_field,
   input  logic [3:0]         old_field,
   input  logic [3:0]         mask,
   input  logic [3:0]         mode,
   input  logic               merge,
   input  logic               pred_bit,
   input  logic               zero_en,
   output logic               wr_en,
   output logic [3:0]         field_out
);

   generate
      if (FIELD_W != 4) begin : g_bad_field
         $error("mcw_field_writer: ports assume a 4-bit field");
      end
   endgenerate

   mcw_variant_e       var_e;
   logic [FIELD_W-1:0] hit;
   logic [FIELD_W-1:0] comb_val;
   logic               legal;
   mcw_wr_t            wr;
   logic               wr_en_q;
   logic [FIELD_W-1:0] field_q;

   assign var_e = mcw_variant_e'(variant);

   mcw_int_match #(.XLEN(XLEN)) match_i (
      .src_int     (src_int),
      .src_is_zero (src_is_zero),
      .bcast       (var_e == MCW_BCAST),
      .mask        (mask),
      .mode        (mode),
      .hit         (hit)
   );

   mcw_combine combine_i (
      .variant   (var_e),
      .hit       (hit),
      .src_field (src_field),
      .old_field (old_field),
      .mask      (mask),
      .mode      (mode),
      .merge     (merge),
      .val       (comb_val),
      .legal     (legal)
   );

   mcw_pred_gate #(.PRED_EN(PRED_EN)) gate_i (
      .legal    (legal),
      .val      (comb_val),
      .pred_bit (pred_bit),
      .zero_en  (zero_en),
      .wr       (wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_q <= 1'b0;
         field_q <= '0;
      end else begin
         wr_en_q <= req_valid & wr.we;
         if (req_valid & wr.we) begin
            field_q <= wr.val;
         end
      end
   end

   assign wr_en     = wr_en_q;
   assign field_out = field_q;

endmodule

// File: rtl/mcw_field_writer_chk.sv
module mcw_field_writer_chk #(
   parameter bit PRED_EN = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] variant,
   input logic       src_is_zero,
   input logic [3:0] src_field,
   input logic [3:0] old_field,
   input logic [3:0] mask,
   input logic [3:0] mode,
   input logic       merge,
   input logic       pred_bit,
   input logic       zero_en,
   input logic       wr_en,
   input logic [3:0] field_out
);

   logic pred_ok;
   assign pred_ok = !PRED_EN || pred_bit;

   // R1, R2: zero source in broadcast overwrite gives mask & ~mode
   a_r1_zero_src_bcast: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && variant == 2'b00 && src_is_zero && !merge && pred_ok
      |=> wr_en && field_out == ($past(mask) & ~$past(mode)));

   a_r4_merge_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !variant[1] && merge && pred_ok
      |=> wr_en && ((field_out & ~$past(mask)) == ($past(old_field) & ~$past(mask))));

   a_r4_overwrite_clears: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !variant[1] && !merge && pred_ok
      |=> wr_en && ((field_out & ~$past(mask)) == 4'b0000));

   a_r5_fcopy_masked: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && variant == 2'b10 && pred_ok
      |=> wr_en && (((field_out ^ $past(mode)) & $past(mask)) == ($past(src_field) & $past(mask))));

   a_r7_zeroing: assert property (@(posedge clk) disable iff (!rst_n)
      PRED_EN && req_valid && !pred_bit && zero_en && variant != 2'b11
      |=> wr_en && field_out == 4'b0000);

   a_r8_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      PRED_EN && req_valid && !pred_bit && !zero_en |=> !wr_en);

   a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && variant == 2'b11 |=> !wr_en);

   a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !wr_en);

endmodule

bind mcw_field_writer mcw_field_writer_chk #(.PRED_EN(PRED_EN)) chk_i (.*);

// File: tb/mcw_field_writer_tb.sv
module mcw_field_writer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int XLEN       = 64;
   localparam int WDOG       = 150000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [1:0]      variant = 2'b00;
   logic [XLEN-1:0] src_int = '0;
   logic            src_is_zero = 1'b0;
   logic [3:0]      src_field = '0, old_field = '0, mask = '0, mode = '0;
   logic            merge = 1'b0, pred_bit = 1'b1, zero_en = 1'b0;
   logic            wr_en;
   logic [3:0]      field_out;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcw_field_writer #(.XLEN(XLEN), .PRED_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .variant(variant),
      .src_int(src_int), .src_is_zero(src_is_zero), .src_field(src_field),
      .old_field(old_field), .mask(mask), .mode(mode), .merge(merge),
      .pred_bit(pred_bit), .zero_en(zero_en), .wr_en(wr_en), .field_out(field_out)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Expected field from the requirement text (R1..R5)
   function automatic logic [3:0] model(input logic [1:0] v, input logic [XLEN-1:0] s,
                                        input logic z, input logic [3:0] sf, input logic [3:0] old,
                                        input logic [3:0] m, input logic [3:0] md, input logic mg);
      logic [XLEN-1:0] a;
      logic [3:0]      keep, n;
      a    = z ? '0 : s;
      keep = mg ? (old & ~m) : 4'b0000;
      for (int k = 0; k < 4; k++) begin
         logic t;
         t    = (v == 2'b00) ? a[0] : a[k];
         n[k] = m[k] && (md[k] == t);
      end
      if (v == 2'b10) return ((m & sf) | keep) ^ md;
      return n | keep;
   endfunction

   task automatic issue(input logic [1:0] v, input logic [XLEN-1:0] s, input logic z,
                        input logic [3:0] sf, input logic [3:0] old, input logic [3:0] m,
                        input logic [3:0] md, input logic mg, input logic pb, input logic ze,
                        output logic got_we, output logic [3:0] got_val);
      @(negedge clk);
      req_valid = 1'b1; variant = v; src_int = s; src_is_zero = z; src_field = sf;
      old_field = old; mask = m; mode = md; merge = mg; pred_bit = pb; zero_en = ze;
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      got_we  = wr_en;
      got_val = field_out;
   endtask

   task automatic t_reset();
      check(wr_en == 1'b0, "R10 reset wr_en", wr_en, 0);
      check(field_out == 4'h0, "R10 reset field_out", field_out, 0);
   endtask

   task automatic t_broadcast();
      logic we; logic [3:0] v, e;
      for (int m = 0; m < 16; m++)
         for (int md = 0; md < 16; md++)
            for (int b = 0; b < 2; b++)
               for (int mg = 0; mg < 2; mg++) begin
                  logic [XLEN-1:0] s;
                  logic [3:0] old;
                  s   = 64'hA5A5_0000_0000_000E | XLEN'(b);
                  old = 4'(m) ^ 4'(md) ^ 4'h6;
                  issue(2'b00, s, 1'b0, 4'hF, old, 4'(m), 4'(md), 1'(mg), 1'b1, 1'b0, we, v);
                  e = model(2'b00, s, 1'b0, 4'hF, old, 4'(m), 4'(md), 1'(mg));
                  check(we == 1'b1, "R2 broadcast wr_en", we, 1);
                  check(v == e, mg ? "R2 R4 broadcast merge" : "R2 R4 broadcast overwrite", v, e);
               end
   endtask

   task automatic t_perbit();
      logic we; logic [3:0] v, e;
      for (int m = 0; m < 16; m++)
         for (int md = 0; md < 16; md++)
            for (int nib = 0; nib < 16; nib++) begin
               logic [XLEN-1:0] s;
               logic [3:0] old;
               logic mg;
               mg  = 1'(nib ^ md);
               s   = {4'(m), 56'h0, 4'(~nib)} << 0;
               s[3:0] = 4'(nib);
               s[7:4] = 4'(~nib);
               old = 4'(nib) ^ 4'h9;
               issue(2'b01, s, 1'b0, 4'h0, old, 4'(m), 4'(md), mg, 1'b1, 1'b0, we, v);
               e = model(2'b01, s, 1'b0, 4'h0, old, 4'(m), 4'(md), mg);
               check(we == 1'b1 && v == e, "R3 R4 per-bit", {27'h0, we, v}, {27'h0, 1'b1, e});
            end
   endtask

   task automatic t_fcopy();
      logic we; logic [3:0] v, e;
      for (int m = 0; m < 16; m++)
         for (int md = 0; md < 16; md++)
            for (int sf = 0; sf < 16; sf++)
               for (int mg = 0; mg < 2; mg++) begin
                  logic [3:0] old;
                  old = 4'(sf) ^ 4'(m) ^ 4'hC;
                  issue(2'b10, '1, 1'b0, 4'(sf), old, 4'(m), 4'(md), 1'(mg), 1'b1, 1'b0, we, v);
                  e = model(2'b10, '1, 1'b0, 4'(sf), old, 4'(m), 4'(md), 1'(mg));
                  check(we == 1'b1 && v == e, "R5 field copy", {27'h0, we, v}, {27'h0, 1'b1, e});
               end
   endtask

   task automatic t_zero_src();
      logic we; logic [3:0] v;
      // all-ones register contents must be ignored
      issue(2'b00, '1, 1'b1, 4'h0, 4'h0, 4'hF, 4'h0, 1'b0, 1'b1, 1'b0, we, v);
      check(v == 4'hF, "R1 zero source broadcast", v, 4'hF);
      issue(2'b01, '1, 1'b1, 4'h0, 4'h0, 4'hF, 4'h5, 1'b0, 1'b1, 1'b0, we, v);
      check(v == 4'hA, "R1 zero source per-bit", v, 4'hA);
      for (int m = 0; m < 16; m++) begin
         logic [3:0] old;
         old = 4'(m) ^ 4'h3;
         issue(2'b00, '0, 1'b1, 4'h0, old, 4'(m), 4'h0, 1'b1, 1'b1, 1'b0, we, v);
         check(v == (old | 4'(m)), "R6 set masked bits", v, old | 4'(m));
         issue(2'b00, '0, 1'b1, 4'h0, old, 4'(m), 4'hF, 1'b1, 1'b1, 1'b0, we, v);
         check(v == (old & ~4'(m)), "R6 clear masked bits", v, old & ~4'(m));
      end
   endtask

   task automatic t_pred();
      logic we; logic [3:0] v;
      // establish a nonzero held value first
      issue(2'b10, '0, 1'b0, 4'hF, 4'h0, 4'hF, 4'h0, 1'b0, 1'b1, 1'b0, we, v);
      check(v == 4'hF, "R5 preset", v, 4'hF);
      for (int vr = 0; vr < 3; vr++) begin
         issue(2'(vr), '1, 1'b0, 4'hF, 4'hF, 4'hF, 4'h0, 1'b1, 1'b0, 1'b1, we, v);
         check(we == 1'b1, "R7 zeroing wr_en", we, 1);
         check(v == 4'h0, "R7 zeroing field", v, 0);
         issue(2'(vr), '1, 1'b0, 4'hF, 4'hF, 4'hF, 4'h0, 1'b1, 1'b0, 1'b0, we, v);
         check(we == 1'b0, "R8 no write on false predicate", we, 0);
      end
   endtask

   task automatic t_reserved();
      logic we; logic [3:0] v;
      issue(2'b11, '1, 1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 1'b1, 1'b1, 1'b0, we, v);
      check(we == 1'b0, "R9 reserved variant", we, 0);
      issue(2'b11, '1, 1'b0, 4'hF, 4'hF, 4'hF, 4'hF, 1'b0, 1'b0, 1'b1, we, v);
      check(we == 1'b0, "R9 reserved variant with zeroing", we, 0);
   endtask

   task automatic t_idle();
      logic we; logic [3:0] v;
      issue(2'b00, '0, 1'b1, 4'h0, 4'h0, 4'hF, 4'h0, 1'b0, 1'b1, 1'b0, we, v);
      check(we == 1'b1, "R10 write after request", we, 1);
      @(posedge clk);
      #1;
      check(wr_en == 1'b0, "R10 idle drops wr_en", wr_en, 0);
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", WDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_broadcast();
      t_perbit();
      t_fcopy();
      t_zero_src();
      t_pred();
      t_reserved();
      t_idle();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule